// File: doc/BRIEF.md
# ADC Conversion Result and Status Flag Unit

This unit sits between an analog-to-digital converter and a processor bus. Every time the converter reports a finished conversion (a one-cycle done strobe with a channel index and a 12-bit sample spanning zero to full scale), the sample goes into that channel's own result register and into one shared most-recent-result register. The unit keeps a ready flag per channel, one global ready flag, a lost-sample flag per channel and one global lost-sample flag. Software clears these flags by reading registers, and the clear takes effect in the same cycle as the read.

From the global ready flag, the unit raises a one-cycle transfer request for a DMA engine. It also drives a level interrupt from the status flags, gated by a writable enable mask. All registers are reached over a simple single-cycle select/write bus. Read data is registered and appears in the cycle after the access.

Address map (word addresses on `bus_addr`): 0 mode, 1 interrupt enable, 2 status, 3 per-channel lost-sample flags, 4 most-recent result. Addresses with the top bit set (16 + i) are the result register of channel i. Any other address reads zero.

Top module: `adc_result_flags`

## Requirements
- R1: A done strobe on channel c stores the sample in channel c's result register. Reading address 16+c returns that sample in bits 11:0, with the upper bits zero.
- R2: The most-recent-result register (address 4) returns the latest sample in bits 11:0. It returns that sample's channel number in bits 15:12 when mode bit 0 (tag) is 1, and zero there when mode bit 0 is 0.
- R3: A done strobe on channel c sets status bit c (channel ready) and status bit 16 (global ready).
- R4: Reading address 16+c clears status bit c and leaves the other channel ready bits unchanged.
- R5: Reading address 4 clears status bit 16.
- R6: A done strobe on channel c while status bit c is already 1 sets bit c of the lost-sample register (address 3).
- R7: A done strobe while status bit 16 is already 1 sets status bit 17 (global lost sample).
- R8: Reading address 3 clears all per-channel lost-sample bits. Reading address 2 clears status bit 17. Each read returns the values as they stood before the clear.
- R9: When an event that sets a flag and a read that clears the same flag fall in one cycle, the flag ends up set.
- R10: When mode bit 1 (DMA enable) is 1, `dma_req` is high for exactly the one cycle in which status bit 16 first reads as 1 after being 0. It never goes high while mode bit 1 is 0.
- R11: `irq` is high exactly when some status bit (bits 17:0 of address 2) is 1 and the matching bit of the interrupt-enable register (address 1) is 1.
- R12: After reset, all flags, results, mode and mask are zero. Writes to addresses 0 and 1 read back. `bus_rdata` carries the read value in the cycle after a read access and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| conv_chan | input | 4 | Channel index of the finished conversion |
| conv_data | input | 12 | Sample value of the finished conversion |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| dma_req | output | 1 | One-cycle DMA transfer request |
| irq | output | 1 | Level interrupt |

## Verification
The risky overlap is a finished conversion in the same clock as the bus read that would clear the flag the conversion sets. This covers a channel result read, the most-recent-result read, the lost-sample register read and the status read. The bench provokes each of these overlaps deliberately by asserting the done strobe and the read in one cycle. It judges them in two steps. First, the read data must show the pre-clear value. Second, a follow-up status or lost-sample read must show the flag still set, along with any lost-sample flag implied by the flag's earlier state.

// File: rtl/adc_rf_pkg.sv
package adc_rf_pkg;
  // Word addresses of the low register group.
  localparam int unsigned ADR_MODE   = 0;
  localparam int unsigned ADR_IEN    = 1;
  localparam int unsigned ADR_STAT   = 2;
  localparam int unsigned ADR_LOST   = 3;
  localparam int unsigned ADR_RECENT = 4;

  // Mode register bit positions.
  localparam int unsigned MODE_TAG_BIT = 0;
  localparam int unsigned MODE_DMA_BIT = 1;
  localparam int unsigned MODE_W       = 2;

  localparam int unsigned BUS_W = 32;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_MODE,
    RK_IEN,
    RK_STAT,
    RK_LOST,
    RK_RECENT,
    RK_CHAN
  } rd_kind_e;
endpackage

// File: rtl/adc_rf_capture.sv
module adc_rf_capture #(
  parameter int unsigned NCH = 16,
  parameter int unsigned DW  = 12,
  parameter int unsigned CW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [CW-1:0] conv_chan,
  input  logic [DW-1:0] conv_data,
  input  logic [CW-1:0] sel_idx,
  output logic [DW-1:0] sel_data,
  output logic [DW-1:0] recent_data,
  output logic [CW-1:0] recent_chan
);
  logic [DW-1:0] res_q [NCH];
  logic [NCH-1:0] cap_hit;

  for (genvar g = 0; g < NCH; g++) begin : g_res
    assign cap_hit[g] = conv_done && (conv_chan == CW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)          res_q[g] <= '0;
      else if (cap_hit[g]) res_q[g] <= conv_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recent_data <= '0;
      recent_chan <= '0;
    end else if (conv_done) begin
      recent_data <= conv_data;
      recent_chan <= conv_chan;
    end
  end

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NCH; i++)
      if (sel_idx == CW'(i)) sel_data = res_q[i];
  end

  // R1: the channel result register holds the sample one cycle after its strobe
  p_chan_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> res_q[$past(conv_chan)] == $past(conv_data));
  // R2: the most-recent register follows every strobe
  p_recent_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (recent_data == $past(conv_data)) && (recent_chan == $past(conv_chan)));
  p_one_hit_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cap_hit));
endmodule

// File: rtl/adc_rf_flags.sv
module adc_rf_flags #(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_done,
  input  logic [CW-1:0]  conv_chan,
  input  logic           rd_stat,
  input  logic           rd_lost,
  input  logic           rd_recent,
  input  logic           rd_chan,
  input  logic [CW-1:0]  rd_idx,
  input  logic           dma_en,
  output logic [NCH-1:0] ch_rdy,
  output logic           any_rdy,
  output logic [NCH-1:0] ch_lost,
  output logic           any_lost,
  output logic           dma_req
);
  function automatic logic [NCH-1:0] decode1(input logic [CW-1:0] idx);
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = (idx == CW'(i));
    return v;
  endfunction

  logic [NCH-1:0] rdy_set, rdy_clr, lost_evt;
  logic           glost_evt, rdy_rise;

  assign rdy_set   = conv_done ? decode1(conv_chan) : '0;
  assign rdy_clr   = rd_chan ? decode1(rd_idx) : '0;
  assign lost_evt  = rdy_set & ch_rdy;
  assign glost_evt = conv_done & any_rdy;
  assign rdy_rise  = conv_done & ~any_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_rdy   <= '0;
      any_rdy  <= 1'b0;
      ch_lost  <= '0;
      any_lost <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      ch_rdy   <= (ch_rdy & ~rdy_clr) | rdy_set;
      any_rdy  <= (any_rdy & ~rd_recent) | conv_done;
      ch_lost  <= (rd_lost ? '0 : ch_lost) | lost_evt;
      any_lost <= (any_lost & ~rd_stat) | glost_evt;
      dma_req  <= dma_en & rdy_rise;
    end
  end

  p_rdy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> ch_rdy[$past(conv_chan)] && any_rdy);
  p_rdy_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_chan && !(conv_done && conv_chan == rd_idx) |=> !ch_rdy[$past(rd_idx)]);
  p_any_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_recent && !conv_done |=> !any_rdy);
  p_lost_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && ch_rdy[conv_chan] |=> ch_lost[$past(conv_chan)]);
  p_glost_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && any_rdy |=> any_lost);
  p_lost_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lost && !conv_done |=> ch_lost == '0);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && rd_recent |=> any_rdy);
  p_dma_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);
  p_dma_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> any_rdy && !$past(any_rdy));
endmodule

// File: rtl/adc_rf_regif.sv
module adc_rf_regif
  import adc_rf_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned DW  = 12,
  parameter int unsigned CW  = 4,
  parameter int unsigned AW  = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [NCH-1:0]   ch_rdy,
  input  logic             any_rdy,
  input  logic [NCH-1:0]   ch_lost,
  input  logic             any_lost,
  input  logic [DW-1:0]    sel_data,
  input  logic [DW-1:0]    recent_data,
  input  logic [CW-1:0]    recent_chan,
  output logic [CW-1:0]    sel_idx,
  output logic             rd_stat,
  output logic             rd_lost,
  output logic             rd_recent,
  output logic             rd_chan,
  output logic             mode_tag,
  output logic             mode_dma,
  output logic             irq
);
  localparam int unsigned SW = NCH + 2;

  function automatic logic [BUS_W-1:0] stat_word(input logic [NCH-1:0] r,
                                                 input logic a, input logic l);
    logic [BUS_W-1:0] w;
    w = '0;
    w[NCH-1:0] = r;
    w[NCH]     = a;
    w[NCH+1]   = l;
    return w;
  endfunction

  function automatic logic [BUS_W-1:0] recent_word(input logic [DW-1:0] d,
                                                   input logic [CW-1:0] c,
                                                   input logic tag);
    logic [BUS_W-1:0] w;
    w = '0;
    w[DW-1:0] = d;
    if (tag) w[DW+CW-1:DW] = c;
    return w;
  endfunction

  logic [MODE_W-1:0] mode_q;
  logic [SW-1:0]     ien_q;
  logic              rd_acc, wr_acc;
  rd_kind_e          kind;
  logic [BUS_W-1:0]  rmux, stat_now;

  assign rd_acc = bus_sel & ~bus_wr;
  assign wr_acc = bus_sel & bus_wr;
  assign sel_idx = bus_addr[CW-1:0];

  always_comb begin
    kind = RK_NONE;
    if (bus_addr[AW-1])                      kind = RK_CHAN;
    else if (bus_addr == AW'(ADR_MODE))      kind = RK_MODE;
    else if (bus_addr == AW'(ADR_IEN))       kind = RK_IEN;
    else if (bus_addr == AW'(ADR_STAT))      kind = RK_STAT;
    else if (bus_addr == AW'(ADR_LOST))      kind = RK_LOST;
    else if (bus_addr == AW'(ADR_RECENT))    kind = RK_RECENT;
  end

  assign rd_stat   = rd_acc && kind == RK_STAT;
  assign rd_lost   = rd_acc && kind == RK_LOST;
  assign rd_recent = rd_acc && kind == RK_RECENT;
  assign rd_chan   = rd_acc && kind == RK_CHAN;

  assign stat_now = stat_word(ch_rdy, any_rdy, any_lost);

  always_comb begin
    rmux = '0;
    case (kind)
      RK_MODE:   rmux[MODE_W-1:0] = mode_q;
      RK_IEN:    rmux[SW-1:0] = ien_q;
      RK_STAT:   rmux = stat_now;
      RK_LOST:   rmux[NCH-1:0] = ch_lost;
      RK_RECENT: rmux = recent_word(recent_data, recent_chan, mode_tag);
      RK_CHAN:   rmux[DW-1:0] = sel_data;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      ien_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_acc && kind == RK_MODE) mode_q <= bus_wdata[MODE_W-1:0];
      if (wr_acc && kind == RK_IEN)  ien_q  <= bus_wdata[SW-1:0];
      bus_rdata <= rd_acc ? rmux : '0;
    end
  end

  assign mode_tag = mode_q[MODE_TAG_BIT];
  assign mode_dma = mode_q[MODE_DMA_BIT];
  assign irq = |(stat_now[SW-1:0] & ien_q);

  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> bus_rdata == '0);
  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ch_rdy != '0) || any_rdy || any_lost);
  p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien_q != '0);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stat, rd_lost, rd_recent, rd_chan}));
endmodule

// File: rtl/adc_result_flags.sv
module adc_result_flags
  import adc_rf_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned DW  = 12,
  parameter int unsigned CW  = 4,
  parameter int unsigned AW  = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [CW-1:0]    conv_chan,
  input  logic [DW-1:0]    conv_data,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             dma_req,
  output logic             irq
);
  logic [CW-1:0]  sel_idx, recent_chan;
  logic [DW-1:0]  sel_data, recent_data;
  logic [NCH-1:0] ch_rdy, ch_lost;
  logic           any_rdy, any_lost;
  logic           rd_stat, rd_lost, rd_recent, rd_chan;
  logic           mode_tag, mode_dma;

  adc_rf_capture #(.NCH(NCH), .DW(DW), .CW(CW)) u_capture (
    .clk, .rst_n, .conv_done, .conv_chan, .conv_data,
    .sel_idx, .sel_data, .recent_data, .recent_chan
  );

  adc_rf_flags #(.NCH(NCH), .CW(CW)) u_flags (
    .clk, .rst_n, .conv_done, .conv_chan,
    .rd_stat, .rd_lost, .rd_recent, .rd_chan, .rd_idx(sel_idx),
    .dma_en(mode_dma), .ch_rdy, .any_rdy, .ch_lost, .any_lost, .dma_req
  );

  adc_rf_regif #(.NCH(NCH), .DW(DW), .CW(CW), .AW(AW)) u_regif (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .ch_rdy, .any_rdy, .ch_lost, .any_lost, .sel_data, .recent_data, .recent_chan,
    .sel_idx, .rd_stat, .rd_lost, .rd_recent, .rd_chan, .mode_tag, .mode_dma, .irq
  );

  p_dma_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(mode_dma));
endmodule

// File: tb/test_adc_result_flags.sv
module test_adc_result_flags;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [3:0]  conv_chan = '0;
  logic [11:0] conv_data = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dma_req, irq;

  int n_run = 0;
  int n_fail = 0;

  // Reference state built from the requirements.
  logic [11:0] m_res [16];
  logic [15:0] m_rdy = '0, m_lost = '0;
  logic        m_any = 1'b0, m_glost = 1'b0;
  logic [11:0] m_rdata = '0;
  logic [3:0]  m_rchan = '0;
  logic [1:0]  m_mode = '0;
  logic [17:0] m_ien = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_flags i_adc_result_flags (
    .clk, .rst_n, .conv_done, .conv_chan, .conv_data,
    .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .dma_req, .irq
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_read(input logic [4:0] a);
    logic [31:0] w;
    w = '0;
    if (a[4]) w[11:0] = m_res[a[3:0]];
    else case (a)
      5'd0: w[1:0] = m_mode;
      5'd1: w[17:0] = m_ien;
      5'd2: w = {14'd0, m_glost, m_any, m_rdy};
      5'd3: w[15:0] = m_lost;
      5'd4: begin w[11:0] = m_rdata; if (m_mode[0]) w[15:12] = m_rchan; end
      default: w = '0;
    endcase
    return w;
  endfunction

  // One bus/converter cycle, starting and ending at a falling edge.
  task automatic cyc(input logic done, input int ch, input logic [11:0] val,
                     input logic sel, input logic wr, input logic [4:0] a,
                     input logic [31:0] wd, input string r);
    logic [31:0] exp_rd;
    logic        exp_dma, rd;
    logic [15:0] set1, clr1;
    conv_done = done; conv_chan = 4'(ch); conv_data = val;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rd = sel && !wr;
    exp_rd = rd ? expect_read(a) : 32'd0;
    @(posedge clk);
    set1 = done ? (16'd1 << ch) : 16'd0;
    clr1 = (rd && a[4]) ? (16'd1 << a[3:0]) : 16'd0;
    exp_dma = m_mode[1] && done && !m_any;
    m_lost  = ((rd && a == 5'd3) ? 16'd0 : m_lost) | (set1 & m_rdy);
    m_glost = (m_glost && !(rd && a == 5'd2)) || (done && m_any);
    m_rdy   = (m_rdy & ~clr1) | set1;
    m_any   = (m_any && !(rd && a == 5'd4)) || done;
    if (done) begin m_res[ch] = val; m_rdata = val; m_rchan = 4'(ch); end
    if (sel && wr && a == 5'd0) m_mode = wd[1:0];
    if (sel && wr && a == 5'd1) m_ien = wd[17:0];
    @(negedge clk);
    chk(rd ? r : "R12", bus_rdata, exp_rd);
    chk("R10", {31'd0, dma_req}, {31'd0, exp_dma});
    chk("R11", {31'd0, irq}, {31'd0, |({m_glost, m_any, m_rdy} & m_ien)});
    conv_done = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string r);
    cyc(1'b0, 0, 12'd0, 1'b1, 1'b0, a, 32'd0, r);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b0, 0, 12'd0, 1'b1, 1'b1, a, d, "R12");
  endtask
  task automatic conv(input int ch, input logic [11:0] v);
    cyc(1'b1, ch, v, 1'b0, 1'b0, 5'd0, 32'd0, "R3");
  endtask
  task automatic clear_all();
    for (int c = 0; c < 16; c++) rd(5'(16 + c), "R4");
    rd(5'd4, "R5"); rd(5'd2, "R8"); rd(5'd3, "R8");
  endtask

  function automatic logic [11:0] sample(input int ch, input int k);
    return 12'((ch * 273 + k * 1000 + 7) & 12'hfff);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) m_res[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state
    for (int a = 0; a < 8; a++) rd(5'(a), "R12");
    rd(5'd21, "R12");
    wr(5'd0, 32'h3); wr(5'd1, 32'h3ffff);
    rd(5'd0, "R12"); rd(5'd1, "R12");
    // Sweep every channel: capture, flags, clears, tag
    for (int c = 0; c < 16; c++) begin
      conv(c, sample(c, 1));
      rd(5'd2, "R3");
      rd(5'(16 + c), "R1");
      rd(5'd2, "R4");
      rd(5'd4, "R2");
      rd(5'd2, "R5");
    end
    // Overruns
    conv(5, sample(5, 2)); conv(5, sample(5, 3)); conv(9, sample(9, 2));
    rd(5'd3, "R6"); rd(5'd3, "R8");
    rd(5'd2, "R7"); rd(5'd2, "R8");
    rd(5'(16 + 5), "R1");
    clear_all();
    // R9: same-cycle set and clear
    conv(3, sample(3, 4));
    cyc(1'b1, 3, sample(3, 5), 1'b1, 1'b0, 5'd19, 32'd0, "R9");
    rd(5'd2, "R9"); rd(5'd3, "R9");
    cyc(1'b1, 4, sample(4, 5), 1'b1, 1'b0, 5'd4, 32'd0, "R9");
    rd(5'd2, "R9");
    conv(6, sample(6, 5));
    cyc(1'b1, 6, sample(6, 6), 1'b1, 1'b0, 5'd3, 32'd0, "R9");
    rd(5'd3, "R9");
    cyc(1'b1, 7, sample(7, 6), 1'b1, 1'b0, 5'd2, 32'd0, "R9");
    rd(5'd2, "R9");
    clear_all();
    // R2 with tagging off, R10 with DMA off
    wr(5'd0, 32'h0);
    conv(11, sample(11, 7));
    rd(5'd4, "R2");
    conv(12, sample(12, 7));
    rd(5'd4, "R2");
    clear_all();
    // R11: each enable bit alone
    wr(5'd0, 32'h2);
    for (int b = 0; b < 18; b++) begin
      wr(5'd1, 32'd1 << b);
      conv(b % 16, sample(b, 8));
      conv(b % 16, sample(b, 9));
      rd(5'd2, "R11");
      clear_all();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule